// File: doc/BRIEF.md
# PLL Lock Status Tracker

This block decides whether a phase-locked loop counts as locked. It also keeps a sticky flag that records a loss of lock, and it produces an enable for the gate on the PLL output clock.

An internal counter watches a per-reference-cycle tolerance indication. Lock is declared once the counter has seen a programmable number of consecutive in-tolerance reference cycles. Lock is forced clear by any of these events, and each time the count must be rebuilt from zero:

- a change of the reference divider or the feedback multiplier
- absence of the reference clock
- a stop entry that shuts the loop down

The clock-gate enable is high only while the loop is enabled and locked. The output clock is therefore withheld whenever lock is being reacquired.

Software sees the lock status and the sticky flag. It clears the sticky flag with a one-cycle write-one pulse. Only unplanned losses set the flag: a tolerance failure or a missing reference. Lock dropped through a settings change, a stop entry or disabling the loop leaves the flag as it was.

Top module: `pll_lock_tracker`

## Requirements
- R1: While rst_ni is low, lock_o, lol_o and clk_gate_en_o are 0.
- R2: The loop counts as enabled when mode_pll_i or pll_clk_en_i is 1. While it is enabled, the reference is present and no clear condition holds, each cycle with ref_tick_i=1 and in_tol_i=1 advances the count. A cycle with ref_tick_i=0 holds the count. lock_o becomes 1 in the cycle after the LOCK_CNT-th consecutive good tick.
- R3: A cycle with ref_tick_i=1 and in_tol_i=0 restarts the count. If lock_o was 1, lock_o is 0 in the next cycle and lol_o becomes 1.
- R4: A value of ref_div_i or mult_i that differs from the previous cycle's value clears lock_o in the next cycle without setting lol_o. This holds even when the reference is lost in the same cycle. Counting restarts afterwards.
- R5: A cycle with ref_present_i=0 while locked clears lock_o in the next cycle and sets lol_o. Lock stays clear until LOCK_CNT good ticks follow the return of the reference.
- R6: Stop entry is signalled by a stop_enter_i pulse. It shuts the loop down when stop_kind_i is not 2'b00 (01 low-leakage, 10 very-low-power, 11 reserved) or when stop_kind_i is 2'b00 with pll_stop_en_i=0. A shut-down entry clears lock_o in the next cycle without setting lol_o, and counting stays blocked through the cycle of the stop_exit_i pulse. Stop entry with kind 2'b00 and pll_stop_en_i=1 has no effect.
- R7: A lol_clr_i pulse clears lol_o in the next cycle. If a loss occurs in the same cycle, lol_o is 1.
- R8: When the loop is disabled, lock_o is 0 from the next cycle and lol_o holds its value.
- R9: clk_gate_en_o equals 1 exactly when the loop is enabled and lock_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pll_i | input | 1 | Clock mode selects the PLL |
| pll_clk_en_i | input | 1 | Explicit PLL enable |
| ref_tick_i | input | 1 | One pulse per reference cycle |
| in_tol_i | input | 1 | Reference cycle within lock tolerance |
| ref_present_i | input | 1 | Reference clock present |
| ref_div_i | input | DIV_W | Reference divider setting |
| mult_i | input | MUL_W | Feedback multiplier setting |
| stop_enter_i | input | 1 | Stop entry pulse |
| stop_exit_i | input | 1 | Stop exit pulse |
| stop_kind_i | input | 2 | Stop kind: 00 normal, 01 low-leakage, 10 very-low-power, 11 reserved |
| pll_stop_en_i | input | 1 | Keep the PLL running in normal stop |
| lol_clr_i | input | 1 | Write-one-to-clear pulse for the sticky flag |
| lock_o | output | 1 | Lock status |
| lol_o | output | 1 | Sticky loss-of-lock flag |
| clk_gate_en_o | output | 1 | Enable for the PLL output clock gate |

## Verification
The bench builds the block with LOCK_CNT set to 4 and both setting widths left at 5. With these values, lock can be acquired, lost and regained many times within a few dozen cycles. Each clear cause can be tried from the locked state. The bench covers several priority cases, each in the same cycle: a settings change with a missing reference, a tolerance failure with a clear pulse, and a stop exit with counting still blocked.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    STOP_NORMAL   = 2'b00,
    STOP_LOW_LEAK = 2'b01,
    STOP_VLP      = 2'b10,
    STOP_RSVD     = 2'b11
  } stop_kind_e;

  // normal stop keeps the loop alive only when the stop enable is set
  function automatic logic stop_kills_loop(stop_kind_e kind, logic keep_en);
    return (kind != STOP_NORMAL) || !keep_en;
  endfunction
endpackage

// File: rtl/pll_lock_qual.sv
module pll_lock_qual
  import pll_lock_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned MUL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pll_i,
  input  logic             pll_clk_en_i,
  input  logic [DIV_W-1:0] ref_div_i,
  input  logic [MUL_W-1:0] mult_i,
  input  logic             ref_present_i,
  input  logic             stop_enter_i,
  input  logic             stop_exit_i,
  input  logic [1:0]       stop_kind_i,
  input  logic             pll_stop_en_i,
  output logic             pll_en_o,
  output logic             cfg_chg_o,
  output logic             stop_kill_o,
  output logic             block_o
);
  logic [DIV_W-1:0] div_q;
  logic [MUL_W-1:0] mul_q;
  logic             stop_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      mul_q <= '0;
    end else begin
      div_q <= ref_div_i;
      mul_q <= mult_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stop_hold_q <= 1'b0;
    else if (stop_kill_o) stop_hold_q <= 1'b1;
    else if (stop_exit_i) stop_hold_q <= 1'b0;
  end

  assign pll_en_o    = mode_pll_i | pll_clk_en_i;
  assign cfg_chg_o   = (ref_div_i != div_q) || (mult_i != mul_q);
  assign stop_kill_o = stop_enter_i && stop_kills_loop(stop_kind_e'(stop_kind_i), pll_stop_en_i);
  assign block_o     = !pll_en_o || cfg_chg_o || !ref_present_i || stop_kill_o || stop_hold_q;
endmodule

// File: rtl/pll_lock_count.sv
module pll_lock_count #(
  parameter int unsigned LOCK_CNT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  input  logic tol_i,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CNT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_i || (tick_i && !tol_i)) cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign locked_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pll_lol_flag.sv
module pll_lol_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic lol_o
);
  logic lol_q;

  // a loss in the clearing cycle must not be missed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lol_q <= 1'b0;
    else         lol_q <= set_i | (lol_q & ~clr_i);
  end

  assign lol_o = lol_q;
endmodule

// File: rtl/pll_lock_tracker.sv
module pll_lock_tracker #(
  parameter int unsigned LOCK_CNT = 64,
  parameter int unsigned DIV_W    = 5,
  parameter int unsigned MUL_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pll_i,
  input  logic             pll_clk_en_i,
  input  logic             ref_tick_i,
  input  logic             in_tol_i,
  input  logic             ref_present_i,
  input  logic [DIV_W-1:0] ref_div_i,
  input  logic [MUL_W-1:0] mult_i,
  input  logic             stop_enter_i,
  input  logic             stop_exit_i,
  input  logic [1:0]       stop_kind_i,
  input  logic             pll_stop_en_i,
  input  logic             lol_clr_i,
  output logic             lock_o,
  output logic             lol_o,
  output logic             clk_gate_en_o
);
  logic pll_en, cfg_chg, stop_kill, block, locked, lol_set;

  pll_lock_qual #(.DIV_W(DIV_W), .MUL_W(MUL_W)) i_qual (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_pll_i    (mode_pll_i),
    .pll_clk_en_i  (pll_clk_en_i),
    .ref_div_i     (ref_div_i),
    .mult_i        (mult_i),
    .ref_present_i (ref_present_i),
    .stop_enter_i  (stop_enter_i),
    .stop_exit_i   (stop_exit_i),
    .stop_kind_i   (stop_kind_i),
    .pll_stop_en_i (pll_stop_en_i),
    .pll_en_o      (pll_en),
    .cfg_chg_o     (cfg_chg),
    .stop_kill_o   (stop_kill),
    .block_o       (block)
  );

  pll_lock_count #(.LOCK_CNT(LOCK_CNT)) i_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (block),
    .tick_i   (ref_tick_i),
    .tol_i    (in_tol_i),
    .locked_o (locked)
  );

  // only unplanned losses are recorded
  assign lol_set = locked && pll_en && !cfg_chg && !stop_kill &&
                   (!ref_present_i || (ref_tick_i && !in_tol_i));

  pll_lol_flag i_lol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (lol_set),
    .clr_i  (lol_clr_i),
    .lol_o  (lol_o)
  );

  assign lock_o        = locked;
  assign clk_gate_en_o = pll_en && locked;
endmodule

// File: rtl/pll_lock_tracker_chk.sv
module pll_lock_tracker_chk #(
  parameter int unsigned LOCK_CNT = 64,
  parameter int unsigned DIV_W    = 5,
  parameter int unsigned MUL_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_pll_i,
  input logic             pll_clk_en_i,
  input logic             ref_tick_i,
  input logic             in_tol_i,
  input logic             ref_present_i,
  input logic [DIV_W-1:0] ref_div_i,
  input logic [MUL_W-1:0] mult_i,
  input logic             stop_enter_i,
  input logic             stop_exit_i,
  input logic [1:0]       stop_kind_i,
  input logic             pll_stop_en_i,
  input logic             lol_clr_i,
  input logic             lock_o,
  input logic             lol_o,
  input logic             clk_gate_en_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!lock_o && !lol_o && !clk_gate_en_o);
    end
  end

  p_lock_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_tick_i && in_tol_i && ref_present_i));

  p_tol_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && ref_tick_i && !in_tol_i |=> !lock_o);

  p_cfg_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && (ref_div_i != $past(ref_div_i) || mult_i != $past(mult_i)) |=> !lock_o);

  p_ref_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && !ref_present_i |=> !lock_o);

  p_stop_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_enter_i && (stop_kind_i != 2'b00 || !pll_stop_en_i) |=> !lock_o);

  p_lol_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_o && !lol_clr_i |=> lol_o);

  p_lol_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_clr_i && !lock_o |=> !lol_o);

  p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_pll_i && !pll_clk_en_i |=> !lock_o);

  p_gate_needs_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> !clk_gate_en_o);
endmodule

bind pll_lock_tracker pll_lock_tracker_chk #(
  .LOCK_CNT (LOCK_CNT),
  .DIV_W    (DIV_W),
  .MUL_W    (MUL_W)
) i_chk (.*);

// File: tb/test_pll_lock_tracker.sv
`timescale 1ns/1ps
module test_pll_lock_tracker;
  localparam int unsigned LOCK_CNT = 4;
  localparam int unsigned DIV_W    = 5;
  localparam int unsigned MUL_W    = 5;

  typedef struct packed {
    logic       mode;
    logic       en;
    logic       tick;
    logic       tol;
    logic       refp;
    logic [4:0] div;
    logic [4:0] mul;
    logic       sin;
    logic       sout;
    logic [1:0] kind;
    logic       sen;
    logic       clr;
    logic [2:0] exp;   // lock, lol, gate
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b01011, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b01101, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b10, 3'b111},
    {5'b01111, 5'd3, 5'd7, 2'b00, 2'b00, 2'b11, 3'b101},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b01110, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01110, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b11, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b01111, 5'd4, 5'd7, 2'b10, 2'b00, 2'b10, 3'b101},
    {5'b01111, 5'd4, 5'd7, 2'b01, 2'b00, 2'b10, 3'b101},
    {5'b01111, 5'd4, 5'd7, 2'b10, 2'b01, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b01, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000},
    {5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b10111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101},
    {5'b00111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}
  };

  function automatic string row_tag(int i);
    if (i <= 5)  return "R2";
    if (i <= 10) return "R3";
    if (i == 11) return "R7";
    if (i <= 16) return "R4";
    if (i <= 22) return "R5";
    if (i <= 32) return "R6";
    if (i == 33) return "R2";
    return "R8";
  endfunction

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b1;
  logic             mode_pll_i = 1'b0, pll_clk_en_i = 1'b0;
  logic             ref_tick_i = 1'b0, in_tol_i = 1'b0, ref_present_i = 1'b0;
  logic [DIV_W-1:0] ref_div_i = '0;
  logic [MUL_W-1:0] mult_i = '0;
  logic             stop_enter_i = 1'b0, stop_exit_i = 1'b0;
  logic [1:0]       stop_kind_i = 2'b00;
  logic             pll_stop_en_i = 1'b0, lol_clr_i = 1'b0;
  logic             lock_o, lol_o, clk_gate_en_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pll_lock_tracker #(.LOCK_CNT(LOCK_CNT), .DIV_W(DIV_W), .MUL_W(MUL_W)) i_pll_lock_tracker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_pll_i    (mode_pll_i),
    .pll_clk_en_i  (pll_clk_en_i),
    .ref_tick_i    (ref_tick_i),
    .in_tol_i      (in_tol_i),
    .ref_present_i (ref_present_i),
    .ref_div_i     (ref_div_i),
    .mult_i        (mult_i),
    .stop_enter_i  (stop_enter_i),
    .stop_exit_i   (stop_exit_i),
    .stop_kind_i   (stop_kind_i),
    .pll_stop_en_i (pll_stop_en_i),
    .lol_clr_i     (lol_clr_i),
    .lock_o        (lock_o),
    .lol_o         (lol_o),
    .clk_gate_en_o (clk_gate_en_o)
  );

  // drive at a falling edge, check at the next one
  task automatic apply(input vec_t v, input string tag);
    mode_pll_i    = v.mode;
    pll_clk_en_i  = v.en;
    ref_tick_i    = v.tick;
    in_tol_i      = v.tol;
    ref_present_i = v.refp;
    ref_div_i     = v.div;
    mult_i        = v.mul;
    stop_enter_i  = v.sin;
    stop_exit_i   = v.sout;
    stop_kind_i   = v.kind;
    pll_stop_en_i = v.sen;
    lol_clr_i     = v.clr;
    @(negedge clk_i);
    checks++;
    if ({lock_o, lol_o, clk_gate_en_o} !== v.exp) begin
      errors++;
      $display("FAIL %s%s lock/lol/gate actual %b%b%b expected %b", tag,
               (clk_gate_en_o !== v.exp[0]) ? " R9" : "",
               lock_o, lol_o, clk_gate_en_o, v.exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;
    if ({lock_o, lol_o, clk_gate_en_o} !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset actual %b%b%b expected 000", lock_o, lol_o, clk_gate_en_o);
    end
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(TBL[i], row_tag(i));

    // R2 relock after re-enable
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R2");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R2");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R2");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101}, "R2");
    // R7 loss and clear in one cycle: set wins
    apply({5'b01101, 5'd4, 5'd7, 2'b00, 2'b00, 2'b11, 3'b010}, "R7");
    // R8 disabled: sticky holds
    apply({5'b00111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010}, "R8");
    apply({5'b00111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b010}, "R8");
    // R7 clear, then relock
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b11, 3'b000}, "R7");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R2");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R2");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101}, "R2");
    // R6 normal stop without stop enable shuts the loop, no sticky
    apply({5'b01111, 5'd4, 5'd7, 2'b10, 2'b00, 2'b00, 3'b000}, "R6");
    apply({5'b01111, 5'd4, 5'd7, 2'b01, 2'b00, 2'b10, 3'b000}, "R6");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R6");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R6");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b000}, "R6");
    apply({5'b01111, 5'd4, 5'd7, 2'b00, 2'b00, 2'b10, 3'b101}, "R6");
    // R4 multiplier change with reference loss: no sticky
    apply({5'b01110, 5'd4, 5'd9, 2'b00, 2'b00, 2'b10, 3'b000}, "R4");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule